// File: doc/BRIEF.md
# Profiling Buffer Syndrome Register

This block holds the 64-bit status and syndrome word for a profiling or trace buffer. When the buffer write engine reports a management event, the block records why the buffer stopped. It stores a class code, a 6-bit syndrome, a lost-record flag and an external-abort flag, and it sets a service bit. The interrupt output is that service bit, so it stays asserted until software clears the bit.

The meaning of the 6-bit syndrome depends on the class code. For the two data-abort classes it is a fault status code. For the other-event class it is a buffer status code. Codes the block does not support are replaced by zero, and so are reserved class codes written by software. Collision pulses from the engine accumulate in a sticky flag. Only a software write can clear that flag.

Software reads the whole word at any time and writes it with a single-cycle write strobe. A management event in the same cycle takes precedence over the write.

Top module: `prof_syn_reg`

## Requirements
- R1: Bits 63:32, 25:20 and 15:6 of the read word always read as 0.
- R2: On an event, the class field (bits 31:26) becomes 000000 for kind 0 (other event), 100100 for kind 1 (stage-1 abort) and 100101 for kind 2 (stage-2 abort). Kind 3 is treated as kind 0.
- R3: For an abort class, bits 5:0 hold the event code when that code is supported, and 000000 otherwise. The supported codes are 0000xx, 0001xx, 0010xx, 0011xx, 010000, 010001, 0101xx, 100001, 110000 and 110001.
- R4: For the other-event class, bits 5:0 hold 000000 (not filled) or 000001 (filled). Any other input code stores 000000.
- R5: An event is visible on the next clock edge. At that point bit 19 holds the event's lost flag, bit 18 holds its external-abort flag and bit 17 (service) is 1.
- R6: An abort-class event with code 010001 (asynchronous external abort) stores bit 19 as 1, whatever its lost flag.
- R7: The interrupt output equals bit 17 in every cycle.
- R8: A collision pulse sets bit 16 on the next edge. Bit 16 is never cleared except by a software write, and an event does not clear it.
- R9: A software write stores bits 31:26, 19, 18, 17 and 16 from the write data. A reserved class code (anything other than 000000, 100100 or 100101) is stored as 000000. Bits 5:0 are filtered as in R3 and R4 against the stored class.
- R10: When an event and a software write arrive in the same cycle, the event's result is stored and the write is discarded. A collision pulse in that cycle still sets bit 16.
- R11: While reset is asserted, the read word is all zeros and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Management event strobe |
| evt_kind | input | 2 | Event kind: 0 other, 1 stage-1 abort, 2 stage-2 abort |
| evt_code | input | 6 | Fault status or buffer status code |
| evt_lost | input | 1 | Partial record lost |
| evt_ext_abort | input | 1 | External abort seen |
| coll_pulse | input | 1 | Collision event pulse |
| reg_wr_en | input | 1 | Software write strobe |
| reg_wr_data | input | 64 | Software write data |
| reg_rd_data | output | 64 | Current register contents |
| irq | output | 1 | Buffer management interrupt |

## Verification
The main capture path is driven with random events that mix supported and unsupported codes across all four kinds. This separates code filtering done against the wrong class from correct pass-through. Random software writes with arbitrary class fields show whether reserved classes are sanitised and whether the code is filtered against the written class rather than the stored one. Directed cases cover:
- an asynchronous abort with its lost flag low, which exposes a missing force of bit 19;
- an event coinciding with a write, which exposes the wrong priority;
- collision pulses around events and writes, which show whether bit 16 is truly sticky.

// File: rtl/prof_syn_pkg.sv
package prof_syn_pkg;

  localparam int REG_W    = 64;
  localparam int CLS_W    = 6;
  localparam int CODE_W   = 6;
  localparam int CLS_LSB  = 26;
  localparam int LOST_BIT = 19;
  localparam int EA_BIT   = 18;
  localparam int SVC_BIT  = 17;
  localparam int COLL_BIT = 16;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER  = 6'b000000,
    CLS_ABT_S1 = 6'b100100,
    CLS_ABT_S2 = 6'b100101
  } cls_e;

  typedef enum logic [1:0] {
    KIND_OTHER  = 2'd0,
    KIND_ABT_S1 = 2'd1,
    KIND_ABT_S2 = 2'd2,
    KIND_SPARE  = 2'd3
  } kind_e;

  typedef struct packed {
    cls_e              cls;
    logic              lost;
    logic              ea;
    logic              svc;
    logic              coll;
    logic [CODE_W-1:0] code;
  } syn_t;

  localparam logic [CODE_W-1:0] CODE_ASYNC_EA = 6'b010001;

endpackage

// File: rtl/prof_syn_class_map.sv
module prof_syn_class_map
  import prof_syn_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic [CLS_W-1:0] raw_cls,
  output cls_e             evt_cls,
  output cls_e             wr_cls
);

  // Class from an event kind; the spare kind folds to the other class.
  always_comb begin
    case (kind)
      KIND_ABT_S1: evt_cls = CLS_ABT_S1;
      KIND_ABT_S2: evt_cls = CLS_ABT_S2;
      default:     evt_cls = CLS_OTHER;
    endcase
  end

  // Class from software data; reserved codes collapse to the other class.
  always_comb begin
    case (raw_cls)
      6'b100100: wr_cls = CLS_ABT_S1;
      6'b100101: wr_cls = CLS_ABT_S2;
      default:   wr_cls = CLS_OTHER;
    endcase
  end

endmodule

// File: rtl/prof_syn_code_filter.sv
module prof_syn_code_filter
  import prof_syn_pkg::*;
#(
  parameter bit HAS_ALIGN_FAULT  = 1'b1,
  parameter bit HAS_ATOMIC_FAULT = 1'b1
) (
  input  cls_e              cls,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out,
  output logic              is_async_ea
);

  logic is_abort;
  logic ok_level;   // address size / translation / access flag / permission
  logic ok_ext;     // synchronous or asynchronous abort on write
  logic ok_walk;    // synchronous abort on table walk
  logic ok_tlb;
  logic ok_align;
  logic ok_atomic;
  logic abort_ok;
  logic status_ok;

  assign is_abort = (cls != CLS_OTHER);
  assign ok_level = (code_in[5:4] == 2'b00);
  assign ok_ext   = (code_in[5:1] == 5'b01000);
  assign ok_walk  = (code_in[5:2] == 4'b0101);
  assign ok_tlb   = (code_in == 6'b110000);

  generate
    if (HAS_ALIGN_FAULT) begin : g_align
      assign ok_align = (code_in == 6'b100001);
    end else begin : g_no_align
      assign ok_align = 1'b0;
    end
    if (HAS_ATOMIC_FAULT) begin : g_atomic
      assign ok_atomic = (code_in == 6'b110001);
    end else begin : g_no_atomic
      assign ok_atomic = 1'b0;
    end
  endgenerate

  assign abort_ok  = ok_level | ok_ext | ok_walk | ok_tlb | ok_align | ok_atomic;
  assign status_ok = (code_in[5:1] == 5'b00000);

  always_comb begin
    code_out = '0;
    if (is_abort) begin
      if (abort_ok) code_out = code_in;
    end else begin
      if (status_ok) code_out = code_in;
    end
  end

  assign is_async_ea = is_abort && (code_in == CODE_ASYNC_EA);

endmodule

// File: rtl/prof_syn_next.sv
module prof_syn_next
  import prof_syn_pkg::*;
(
  input  syn_t              cur,
  input  logic              evt_valid,
  input  cls_e              evt_cls,
  input  logic [CODE_W-1:0] evt_code_f,
  input  logic              evt_async,
  input  logic              evt_lost,
  input  logic              evt_ext_abort,
  input  logic              coll_pulse,
  input  logic              wr_en,
  input  cls_e              wr_cls,
  input  logic [CODE_W-1:0] wr_code_f,
  input  logic              wr_lost,
  input  logic              wr_ea,
  input  logic              wr_svc,
  input  logic              wr_coll,
  output syn_t              nxt,
  output logic              load
);

  always_comb begin
    nxt  = cur;
    load = evt_valid | wr_en | coll_pulse;
    if (evt_valid) begin
      nxt.cls  = evt_cls;
      nxt.code = evt_code_f;
      nxt.lost = evt_lost | evt_async;
      nxt.ea   = evt_ext_abort;
      nxt.svc  = 1'b1;
      nxt.coll = cur.coll | coll_pulse;
    end else if (wr_en) begin
      nxt.cls  = wr_cls;
      nxt.code = wr_code_f;
      nxt.lost = wr_lost;
      nxt.ea   = wr_ea;
      nxt.svc  = wr_svc;
      nxt.coll = wr_coll | coll_pulse;
    end else begin
      nxt.coll = cur.coll | coll_pulse;
    end
  end

endmodule

// File: rtl/prof_syn_reg.sv
module prof_syn_reg
  import prof_syn_pkg::*;
#(
  parameter bit HAS_ALIGN_FAULT  = 1'b1,
  parameter bit HAS_ATOMIC_FAULT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [1:0]        evt_kind,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              evt_lost,
  input  logic              evt_ext_abort,
  input  logic              coll_pulse,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              irq
);

  cls_e              evt_cls;
  cls_e              wr_cls;
  logic [CODE_W-1:0] evt_code_f;
  logic [CODE_W-1:0] wr_code_f;
  logic              evt_async;
  logic              wr_async_unused;
  syn_t              syn_q;
  syn_t              syn_d;
  logic              syn_load;

  prof_syn_class_map u_class_map (
    .kind    (evt_kind),
    .raw_cls (reg_wr_data[CLS_LSB +: CLS_W]),
    .evt_cls (evt_cls),
    .wr_cls  (wr_cls)
  );

  prof_syn_code_filter #(
    .HAS_ALIGN_FAULT  (HAS_ALIGN_FAULT),
    .HAS_ATOMIC_FAULT (HAS_ATOMIC_FAULT)
  ) u_evt_filter (
    .cls         (evt_cls),
    .code_in     (evt_code),
    .code_out    (evt_code_f),
    .is_async_ea (evt_async)
  );

  prof_syn_code_filter #(
    .HAS_ALIGN_FAULT  (HAS_ALIGN_FAULT),
    .HAS_ATOMIC_FAULT (HAS_ATOMIC_FAULT)
  ) u_wr_filter (
    .cls         (wr_cls),
    .code_in     (reg_wr_data[CODE_W-1:0]),
    .code_out    (wr_code_f),
    .is_async_ea (wr_async_unused)
  );

  prof_syn_next u_next (
    .cur           (syn_q),
    .evt_valid     (evt_valid),
    .evt_cls       (evt_cls),
    .evt_code_f    (evt_code_f),
    .evt_async     (evt_async),
    .evt_lost      (evt_lost),
    .evt_ext_abort (evt_ext_abort),
    .coll_pulse    (coll_pulse),
    .wr_en         (reg_wr_en),
    .wr_cls        (wr_cls),
    .wr_code_f     (wr_code_f),
    .wr_lost       (reg_wr_data[LOST_BIT]),
    .wr_ea         (reg_wr_data[EA_BIT]),
    .wr_svc        (reg_wr_data[SVC_BIT]),
    .wr_coll       (reg_wr_data[COLL_BIT]),
    .nxt           (syn_d),
    .load          (syn_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q <= '{cls: CLS_OTHER, lost: 1'b0, ea: 1'b0, svc: 1'b0,
                 coll: 1'b0, code: '0};
    end else if (syn_load) begin
      syn_q <= syn_d;
    end
  end

  always_comb begin
    reg_rd_data                        = '0;
    reg_rd_data[CLS_LSB +: CLS_W]      = syn_q.cls;
    reg_rd_data[LOST_BIT]              = syn_q.lost;
    reg_rd_data[EA_BIT]                = syn_q.ea;
    reg_rd_data[SVC_BIT]               = syn_q.svc;
    reg_rd_data[COLL_BIT]              = syn_q.coll;
    reg_rd_data[CODE_W-1:0]            = syn_q.code;
  end

  assign irq = syn_q.svc;

endmodule

// File: rtl/prof_syn_reg_chk.sv
module prof_syn_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_valid,
  input logic [1:0]  evt_kind,
  input logic [5:0]  evt_code,
  input logic        coll_pulse,
  input logic        reg_wr_en,
  input logic [63:0] reg_rd_data,
  input logic        irq
);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[63:32] == '0) && (reg_rd_data[25:20] == '0) && (reg_rd_data[15:6] == '0));

  a_r2_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[31:26] == 6'b000000) || (reg_rd_data[31:26] == 6'b100100) ||
    (reg_rd_data[31:26] == 6'b100101));

  a_r5_event_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> reg_rd_data[17]);

  a_r6_async_forces_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_kind == 2'd1 || evt_kind == 2'd2) && evt_code == 6'b010001)
      |=> reg_rd_data[19]);

  a_r7_irq_tracks_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq == reg_rd_data[17]);

  a_r8_coll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |=> reg_rd_data[16]);

  a_r8_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[16] && !reg_wr_en) |=> reg_rd_data[16]);

endmodule

bind prof_syn_reg prof_syn_reg_chk i_prof_syn_reg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_valid   (evt_valid),
  .evt_kind    (evt_kind),
  .evt_code    (evt_code),
  .coll_pulse  (coll_pulse),
  .reg_wr_en   (reg_wr_en),
  .reg_rd_data (reg_rd_data),
  .irq         (irq)
);

// File: tb/test_prof_syn_reg.sv
module test_prof_syn_reg;

  logic        clk;
  logic        rst_n;
  logic        evt_valid;
  logic [1:0]  evt_kind;
  logic [5:0]  evt_code;
  logic        evt_lost;
  logic        evt_ext_abort;
  logic        coll_pulse;
  logic        reg_wr_en;
  logic [63:0] reg_wr_data;
  logic [63:0] reg_rd_data;
  logic        irq;

  int checks;
  int failures;
  int cyc;
  logic [63:0] model;
  logic p_ev, p_we, p_async;

  prof_syn_reg i_prof_syn_reg (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_valid     (evt_valid),
    .evt_kind      (evt_kind),
    .evt_code      (evt_code),
    .evt_lost      (evt_lost),
    .evt_ext_abort (evt_ext_abort),
    .coll_pulse    (coll_pulse),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_data   (reg_wr_data),
    .reg_rd_data   (reg_rd_data),
    .irq           (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] kind_to_cls(input logic [1:0] k);
    if (k == 2'd1) return 6'b100100;
    if (k == 2'd2) return 6'b100101;
    return 6'b000000;
  endfunction

  function automatic logic abort_code_ok(input logic [5:0] c);
    if (c <= 6'd23 && c != 6'd18 && c != 6'd19) return 1'b1;
    if (c == 6'd33 || c == 6'd48 || c == 6'd49) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [5:0] filt(input logic [5:0] cls, input logic [5:0] c);
    if (cls == 6'b000000) return (c <= 6'd1) ? c : 6'd0;
    return abort_code_ok(c) ? c : 6'd0;
  endfunction

  function automatic logic [63:0] step(input logic [63:0] m, input logic ev,
      input logic [1:0] k, input logic [5:0] c, input logic lo, input logic ea,
      input logic cp, input logic we, input logic [63:0] wd);
    logic [63:0] r;
    logic [5:0] cl;
    r = m;
    if (ev) begin
      cl = kind_to_cls(k);
      r = '0;
      r[31:26] = cl;
      r[5:0]   = filt(cl, c);
      r[19]    = lo | ((cl != 6'd0) && c == 6'b010001);
      r[18]    = ea;
      r[17]    = 1'b1;
      r[16]    = m[16] | cp;
    end else if (we) begin
      cl = wd[31:26];
      if (cl != 6'b100100 && cl != 6'b100101) cl = 6'd0;
      r = '0;
      r[31:26] = cl;
      r[5:0]   = filt(cl, wd[5:0]);
      r[19:17] = wd[19:17];
      r[16]    = wd[16] | cp;
    end else begin
      r[16] = m[16] | cp;
    end
    return r;
  endfunction

  task automatic apply(input logic ev, input logic [1:0] k, input logic [5:0] c,
      input logic lo, input logic ea, input logic cp, input logic we,
      input logic [63:0] wd);
    evt_valid = ev; evt_kind = k; evt_code = c; evt_lost = lo;
    evt_ext_abort = ea; coll_pulse = cp; reg_wr_en = we; reg_wr_data = wd;
    model = step(model, ev, k, c, lo, ea, cp, we, wd);
    p_ev = ev; p_we = we;
    p_async = ev && (k == 2'd1 || k == 2'd2) && c == 6'b010001;
    @(negedge clk);
    evt_valid = 1'b0; reg_wr_en = 1'b0; coll_pulse = 1'b0;
    check("R1", {reg_rd_data[63:32], reg_rd_data[25:20], reg_rd_data[15:6]}, '0);
    check(p_ev ? "R2" : "R9", {58'd0, reg_rd_data[31:26]}, {58'd0, model[31:26]});
    check(p_ev ? (model[31:26] == 0 ? "R4" : "R3") : "R9",
          {58'd0, reg_rd_data[5:0]}, {58'd0, model[5:0]});
    check(p_async ? "R6" : "R5", {62'd0, reg_rd_data[19:18]}, {62'd0, model[19:18]});
    check(p_ev ? "R5" : "R9", {63'd0, reg_rd_data[17]}, {63'd0, model[17]});
    check("R7", {63'd0, irq}, {63'd0, model[17]});
    check("R8", {63'd0, reg_rd_data[16]}, {63'd0, model[16]});
    if (p_ev && p_we) check("R10", reg_rd_data, model);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [5:0] rc;
    logic [63:0] wd;
    checks = 0; failures = 0; cyc = 0; model = '0;
    rst_n = 1'b0;
    evt_valid = 0; evt_kind = 0; evt_code = 0; evt_lost = 0; evt_ext_abort = 0;
    coll_pulse = 0; reg_wr_en = 0; reg_wr_data = '0;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check("R11", reg_rd_data, 64'd0);
    check("R11", {63'd0, irq}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    apply(1, 2'd1, 6'b010001, 0, 1, 0, 0, '0);          // R6 async abort, lost low
    apply(0, 0, 0, 0, 0, 0, 1, 64'h0000_0000_0000_0000); // R9 clear via write
    apply(1, 2'd2, 6'b100010, 1, 0, 0, 0, '0);          // R3 unsupported code
    apply(1, 2'd0, 6'd1, 0, 0, 0, 0, '0);               // R4 filled
    apply(1, 2'd3, 6'd5, 0, 0, 0, 0, '0);               // R2 spare kind, R4 bad status
    apply(0, 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_57FF_FFFF); // R9 reserved class 010101
    apply(0, 0, 0, 0, 0, 0, 1, 64'h0000_0000_9002_0031); // R9 abort class, code 110001
    apply(0, 0, 0, 0, 0, 0, 1, 64'h0000_0000_0000_0021); // R9 other class filters 100001
    apply(0, 0, 0, 0, 0, 1, 0, '0);                      // R8 collision
    apply(1, 2'd1, 6'd7, 0, 0, 0, 0, '0);               // R8 event keeps coll
    apply(1, 2'd2, 6'd48, 1, 1, 0, 1, 64'h0000_0000_0000_0000); // R10
    apply(0, 0, 0, 0, 0, 1, 1, 64'h0);                   // R8 pulse wins over clearing write

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic ev, we, cp;
      ev = ($urandom % 10) < 3;
      we = ($urandom % 100) < 15;
      cp = ($urandom % 10) == 0;
      rc = ($urandom % 2) ? 6'($urandom) : 6'(($urandom % 2) ? 17 : ($urandom % 24));
      wd = {$urandom, $urandom};
      if ($urandom % 2) wd[31:26] = kind_to_cls(2'($urandom));
      apply(ev, 2'($urandom), rc, 1'($urandom), 1'($urandom), cp, we, wd);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule